// File: doc/BRIEF.md
# Four-Bit Bidirectional Port with Mode-Dependent Readback

This block is a small memory-mapped I/O port of four pins. Each pin has a direction bit and an output latch bit, and the port has one shared pull-up enable. A register bus presents an opcode, write data and a bit index. The port answers with a nibble of read data and a single test bit. On the pad side it drives data, per-bit output enables and per-bit pull-up enables. The external pin levels are passed through a two-stage synchroniser before any logic uses them.

What the port reads back depends on the direction of each bit. A bit set as input returns the synchronised pin. A bit set as output returns its latch. The same mixed view feeds every read-modify-write operation. An exchange returns the view and loads the written value. An increment loads the view plus one, so an increment on an input pin stores the pin value plus one. A nibble write always updates the latch, even for pins whose driver is off. Single-bit set and clear change only the addressed latch bit.

The opcode decode is an enumerated case over ten operations: idle, nibble write, nibble read, exchange, increment, bit set, bit clear, bit test, direction write and pull-up write. There is no hidden state beyond the latch, direction and pull-up registers and the synchroniser. Every operation completes in the cycle it is presented, and its register update appears after that cycle's rising edge.

Top module: `iop_port`

## Requirements
- R1: After reset, `pad_do_o`, `pad_oe_o` and `pad_pu_o` are all zero, so every pin is an input with its driver off and no pull-up.
- R2: `pad_oe_o` equals the direction register, where 1 means output, and `pad_do_o` equals the output latch. The direction register is loaded from `wdata_i` by opcode 8.
- R3: `rd_data_o` bit i equals latch bit i when direction bit i is 1. Otherwise it equals the synchronised pin bit i.
- R4: Nibble write (opcode 1) loads `wdata_i` into the latch after the edge, whatever the direction. It leaves `pad_oe_o` unchanged.
- R5: Exchange (opcode 3) presents the current readback view on `rd_data_o` during its cycle and loads `wdata_i` into the latch after the edge.
- R6: Increment (opcode 4) loads (readback view + 1) mod 16 into the latch. This means pin+1 for input bits and latch+1 for output bits.
- R7: Bit set (opcode 5) and bit clear (opcode 6) write 1 or 0 to latch bit `bit_sel_i` only. All other latch bits keep their values, in either direction.
- R8: `rd_bit_o` equals bit `bit_sel_i` of the readback view. Bit test is opcode 7.
- R9: `pad_pu_o` bit i is 1 exactly when the pull-up enable is 1 and direction bit i is 0. The pull-up enable is loaded from `wdata_i[0]` by opcode 9.
- R10: A pin change made between edges shows on `rd_data_o` for an input bit after the second following rising edge, not after the first.
- R11: Idle (0), nibble read (2) and bit test (7) leave the latch, the direction and the pull-up outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code (0 to 9, others idle) |
| wdata_i | input | 4 | Write data for write, exchange, direction and pull-up operations |
| bit_sel_i | input | 2 | Bit index for set, clear and test |
| pin_i | input | 4 | External pin levels, asynchronous |
| rd_data_o | output | 4 | Readback view: latch for output bits, synchronised pin for input bits |
| rd_bit_o | output | 1 | Addressed bit of the readback view |
| pad_do_o | output | 4 | Pad drive data (the latch) |
| pad_oe_o | output | 4 | Pad output enables (the direction register) |
| pad_pu_o | output | 4 | Pad pull-up enables |

## Verification
The bench uses the default width of four pins and a two-stage synchroniser. At that size it can sweep every combination of direction, latch and pin value, 4096 in all. For each combination it checks the readback nibble, every test bit, the exchange result and the increment result. It also sweeps set and clear over every latch value and bit index in both directions, and sweeps the pull-up over every direction pattern. A separate timed step checks that a pin change appears after two edges and not after one.

// File: rtl/iop_pkg.sv
package iop_pkg;
    localparam int PORT_W = 4;
    localparam int SEL_W  = $clog2(PORT_W);
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_IDLE  = 4'd0,
        OP_WRITE = 4'd1,
        OP_READ  = 4'd2,
        OP_XCHG  = 4'd3,
        OP_INCR  = 4'd4,
        OP_BSET  = 4'd5,
        OP_BCLR  = 4'd6,
        OP_BTEST = 4'd7,
        OP_DIRW  = 4'd8,
        OP_PUW   = 4'd9
    } iop_op_e;
endpackage

// File: rtl/iop_sync.sv
module iop_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/iop_view.sv
module iop_view #(
    parameter int W     = 4,
    parameter int SEL_W = 2
) (
    input  logic [W-1:0]     latch_i,
    input  logic [W-1:0]     dir_i,
    input  logic [W-1:0]     pin_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [W-1:0]     view_o,
    output logic             bit_o
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            assign view_o[i] = dir_i[i] ? latch_i[i] : pin_i[i];
        end
    endgenerate

    assign bit_o = view_o[sel_i];
endmodule

// File: rtl/iop_regs.sv
module iop_regs
    import iop_pkg::*;
#(
    parameter int W     = 4,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  iop_op_e          op_i,
    input  logic [W-1:0]     wdata_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [W-1:0]     view_i,
    output logic [W-1:0]     latch_o,
    output logic [W-1:0]     dir_o,
    output logic             pu_en_o
);
    logic [W-1:0] latch_q, latch_n;
    logic [W-1:0] dir_q, dir_n;
    logic         pu_q, pu_n;

    always_comb begin
        latch_n = latch_q;
        dir_n   = dir_q;
        pu_n    = pu_q;
        unique case (op_i)
            OP_WRITE: latch_n = wdata_i;
            OP_XCHG:  latch_n = wdata_i;
            OP_INCR:  latch_n = W'(view_i + 1'b1);
            OP_BSET:  latch_n[sel_i] = 1'b1;
            OP_BCLR:  latch_n[sel_i] = 1'b0;
            OP_DIRW:  dir_n = wdata_i;
            OP_PUW:   pu_n = wdata_i[0];
            OP_IDLE, OP_READ, OP_BTEST: ;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '0;
            pu_q    <= 1'b0;
        end else begin
            latch_q <= latch_n;
            dir_q   <= dir_n;
            pu_q    <= pu_n;
        end
    end

    assign latch_o = latch_q;
    assign dir_o   = dir_q;
    assign pu_en_o = pu_q;
endmodule

// File: rtl/iop_port.sv
module iop_port
    import iop_pkg::*;
#(
    parameter int W           = PORT_W,
    parameter int SYNC_STAGES = 2,
    localparam int SW         = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [SW-1:0] bit_sel_i,
    input  logic [W-1:0]  pin_i,
    output logic [W-1:0]  rd_data_o,
    output logic          rd_bit_o,
    output logic [W-1:0]  pad_do_o,
    output logic [W-1:0]  pad_oe_o,
    output logic [W-1:0]  pad_pu_o
);
    logic [W-1:0] pin_s;
    logic [W-1:0] latch, dir, view;
    logic         pu_en;
    iop_op_e      op;

    assign op = iop_op_e'(op_i);

    iop_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_s)
    );

    iop_view #(.W(W), .SEL_W(SW)) u_view (
        .latch_i(latch), .dir_i(dir), .pin_i(pin_s), .sel_i(bit_sel_i),
        .view_o(view), .bit_o(rd_bit_o)
    );

    iop_regs #(.W(W), .SEL_W(SW)) u_regs (
        .clk(clk), .rst_n(rst_n), .op_i(op), .wdata_i(wdata_i),
        .sel_i(bit_sel_i), .view_i(view),
        .latch_o(latch), .dir_o(dir), .pu_en_o(pu_en)
    );

    assign rd_data_o = view;
    assign pad_do_o  = latch;
    assign pad_oe_o  = dir;
    assign pad_pu_o  = ~dir & {W{pu_en}};
endmodule

// File: rtl/iop_port_chk.sv
module iop_port_chk #(
    parameter int W  = 4,
    parameter int SW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    op_i,
    input logic [W-1:0]  wdata_i,
    input logic [SW-1:0] bit_sel_i,
    input logic [W-1:0]  rd_data_o,
    input logic [W-1:0]  pad_do_o,
    input logic [W-1:0]  pad_oe_o,
    input logic [W-1:0]  pad_pu_o
);
    assert_write_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd1) |=> (pad_do_o == $past(wdata_i) && $stable(pad_oe_o)));

    assert_xchg_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd3) |=> (pad_do_o == $past(wdata_i)));

    assert_incr_output_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd4 && pad_oe_o == {W{1'b1}}) |=> (pad_do_o == W'($past(pad_do_o) + 1'b1)));

    assert_bset_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd5) |=> (pad_do_o == ($past(pad_do_o) | (W'(1) << $past(bit_sel_i)))));

    assert_bclr_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd6) |=> (pad_do_o == ($past(pad_do_o) & ~(W'(1) << $past(bit_sel_i)))));

    assert_out_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_data_o & pad_oe_o) == (pad_do_o & pad_oe_o)));

    assert_pu_inputs_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu_o & pad_oe_o) == '0));

    assert_read_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd2 || op_i == 4'd7 || op_i == 4'd0)
        |=> ($stable(pad_do_o) && $stable(pad_oe_o) && $stable(pad_pu_o)));
endmodule

bind iop_port iop_port_chk #(.W(W), .SW(SW)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .wdata_i(wdata_i),
    .bit_sel_i(bit_sel_i), .rd_data_o(rd_data_o), .pad_do_o(pad_do_o),
    .pad_oe_o(pad_oe_o), .pad_pu_o(pad_pu_o)
);

// File: tb/sim_iop_port.sv
`timescale 1ns/1ps
module sim_iop_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_i = 4'd0;
    logic [3:0] wdata_i = 4'd0;
    logic [1:0] bit_sel_i = 2'd0;
    logic [3:0] pin_i = 4'd0;
    logic [3:0] rd_data_o, pad_do_o, pad_oe_o, pad_pu_o;
    logic       rd_bit_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 0;

    always #2 clk = ~clk;

    iop_port u0 (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .wdata_i(wdata_i),
        .bit_sel_i(bit_sel_i), .pin_i(pin_i), .rd_data_o(rd_data_o),
        .rd_bit_o(rd_bit_o), .pad_do_o(pad_do_o), .pad_oe_o(pad_oe_o),
        .pad_pu_o(pad_pu_o)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] op, input logic [3:0] wd, input logic [1:0] bs);
        @(negedge clk);
        op_i = op; wdata_i = wd; bit_sel_i = bs;
        #0.5;
    endtask

    task automatic idle();
        drive(4'd0, 4'd0, 2'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #0.5;
        chk("R1 do", pad_do_o, 0);
        chk("R1 oe", pad_oe_o, 0);
        chk("R1 pu", pad_pu_o, 0);
        rst_n = 1'b1;

        // R10: two-edge synchroniser latency on an input bit
        drive(4'd8, 4'h0, 2'd0);
        @(negedge clk); op_i = 4'd0; pin_i = 4'hA;
        @(negedge clk); #0.5;
        chk("R10 one edge", rd_data_o, 4'h0);
        @(negedge clk); #0.5;
        chk("R10 two edges", rd_data_o, 4'hA);

        // R3 R5 R6 R8 R4 R2: sweep direction x latch x pin
        for (int d = 0; d < 16; d++) begin
            for (int l = 0; l < 16; l++) begin
                for (int p = 0; p < 16; p++) begin
                    int view;
                    drive(4'd1, 4'(l), 2'd0);
                    drive(4'd8, 4'(d), 2'd0);
                    pin_i = 4'(p);
                    idle(); idle();
                    view = (d & l) | (~d & p & 15);
                    chk("R2 oe", pad_oe_o, d);
                    chk("R4 write", pad_do_o, l);
                    chk("R3 view", rd_data_o, view);
                    for (int b = 0; b < 4; b++) begin
                        drive(4'd7, 4'd0, 2'(b));
                        chk("R8 test bit", rd_bit_o, (view >> b) & 1);
                    end
                    drive(4'd3, 4'(~l), 2'd0);
                    chk("R5 xchg read", rd_data_o, view);
                    idle();
                    chk("R5 xchg load", pad_do_o, (~l) & 15);
                    drive(4'd1, 4'(l), 2'd0);
                    drive(4'd4, 4'd0, 2'd0);
                    idle();
                    chk("R6 incr", pad_do_o, (view + 1) & 15);
                end
            end
        end

        // R7: set/clear in both directions, pins opposite to latch
        for (int d = 0; d < 2; d++) begin
            for (int l = 0; l < 16; l++) begin
                for (int b = 0; b < 4; b++) begin
                    drive(4'd8, d ? 4'hF : 4'h0, 2'd0);
                    drive(4'd1, 4'(l), 2'd0);
                    pin_i = 4'(~l);
                    drive(4'd5, 4'd0, 2'(b));
                    idle();
                    chk("R7 set", pad_do_o, l | (1 << b));
                    drive(4'd1, 4'(l), 2'd0);
                    drive(4'd6, 4'd0, 2'(b));
                    idle();
                    chk("R7 clr", pad_do_o, l & ~(1 << b) & 15);
                end
            end
        end

        // R9: pull-up vs direction
        for (int pu = 0; pu < 2; pu++) begin
            for (int d = 0; d < 16; d++) begin
                drive(4'd9, 4'(pu), 2'd0);
                drive(4'd8, 4'(d), 2'd0);
                idle();
                chk("R9 pull-up", pad_pu_o, pu ? (~d & 15) : 0);
            end
        end

        // R11: read, test and idle leave state alone
        drive(4'd9, 4'd1, 2'd0);
        drive(4'd8, 4'h5, 2'd0);
        drive(4'd1, 4'h9, 2'd0);
        pin_i = 4'h6;
        drive(4'd2, 4'h3, 2'd1);
        drive(4'd7, 4'hC, 2'd2);
        drive(4'd0, 4'hF, 2'd3);
        idle();
        chk("R11 latch", pad_do_o, 4'h9);
        chk("R11 dir", pad_oe_o, 4'h5);
        chk("R11 pu", pad_pu_o, 4'hA);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule